// File: doc/BRIEF.md
# Operating System Timer Core

This block is a free-running system timer for a processor subsystem. A 32-bit counter advances by one on every cycle in which the `tick` enable is high. Four 32-bit compare channels each hold a target value. When the counter steps onto a channel's target and that channel's interrupt is enabled, the block latches a sticky event flag and holds the matching interrupt line high. Software clears a flag by writing a one to its bit in the event register.

The last compare channel also works as a one-shot watchdog. If the watchdog arm bit is set when that channel matches, the block raises a single-cycle reset request and disarms itself. Software reaches every register through a simple single-cycle register bus. Reads return data on the cycle after the strobe. A read of an address that holds no register returns zero and flags a bus error for one cycle.

Register offsets: compare channel n at 4*n (0x00, 0x04, 0x08, 0x0C), counter at 0x10, event flags at 0x14, watchdog arm at 0x18, interrupt enable at 0x1C.

Top module: `ostimer_core`

## Requirements
- R1: After reset the counter, all compare values, the event flags, the interrupt enable, the watchdog arm register, `irq`, `reset_req`, `bus_rdata` and `bus_err` are all zero.
- R2: Each cycle with `tick` high and no counter write adds one to the counter. The count wraps from 0xFFFFFFFF to 0.
- R3: A bus write to offset 0x10 loads the counter with the written value. If `tick` is high in the same cycle, the write takes priority.
- R4: A bus write to offset 4*n (n = 0..3) stores a compare value, and a read of that offset returns it.
- R5: When a tick moves the counter onto the value of compare channel n while enable bit n (bit n of 0x1C) is set, event bit n (bit n of 0x14) and `irq[n]` go high at that same clock edge and stay high.
- R6: If enable bit n is clear when channel n matches, neither event bit n nor `irq[n]` is set, and enabling the channel later does not set them.
- R7: A write to 0x14 clears every event bit whose written bit is 1 and the matching `irq` lines. Event bits written with 0 are unchanged.
- R8: A write to 0x1C keeps only the low 12 bits; a read returns those bits with the upper bits zero.
- R9: When channel 3 matches while bit 0 of the watchdog arm register (0x18) is set, `reset_req` is high for exactly one cycle and the arm register becomes zero. This happens whether or not interrupt enable bit 3 is set.
- R10: A read of any offset other than the eight above returns zero and raises `bus_err` for one cycle. A read of a mapped offset leaves `bus_err` low.
- R11: A compare is made only when a tick advances the counter. Writing a compare value equal to the current count, or loading the counter with a compare value, generates no event.
- R12: `bus_rdata` updates on the clock edge that samples `bus_rd` and holds its value while no read is made.
- R13: If a new event on channel n and a write-one-to-clear of bit n occur in the same cycle, event bit n ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Counter advance enable |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_err | output | 1 | One-cycle flag for a read of an unmapped offset |
| irq | output | 4 | Per-channel interrupt levels |
| reset_req | output | 1 | One-cycle watchdog reset request |

## Verification
Each result has its own fixed delay. Counter, compare and enable writes appear at the edge that samples the strobe. Event bits, `irq` and `reset_req` change at the same edge as the tick that moves the counter onto the compare value. Read data and `bus_err` are due one edge after `bus_rd`. The bench drives every strobe at a falling edge and samples one falling edge later, so each check lands exactly one register stage after its stimulus. The watchdog pulse is checked both on the cycle it is due and on the cycle after, to prove it lasts a single cycle.

// File: rtl/ostimer_pkg.sv
package ostimer_pkg;
    localparam int CNT_W   = 32;
    localparam int ADDR_W  = 8;
    localparam int NUM_CH  = 4;
    localparam int IE_W    = 12;

    localparam logic [ADDR_W-1:0] OFS_COUNT  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_EVENT  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_WDARM  = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_IRQEN  = 8'h1C;

    function automatic logic [ADDR_W-1:0] cmp_ofs(input int idx);
        return ADDR_W'(idx * 4);
    endfunction
endpackage

// File: rtl/ostimer_counter.sv
module ostimer_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_inc,
    output logic         step
);
    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    assign cnt_inc = st_q.cnt + W'(1);
    assign step    = tick && !load_en;
    assign cnt_q   = st_q.cnt;

    always_comb begin
        st_d = st_q;
        if (load_en) begin
            st_d.cnt = load_val;
        end else if (tick) begin
            st_d.cnt = cnt_inc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_en) |=> (cnt_q == $past(cnt_q) + W'(1)));

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (cnt_q == $past(load_val)));
endmodule

// File: rtl/ostimer_cmp_ch.sv
module ostimer_cmp_ch #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_val,
    input  logic         step,
    input  logic [W-1:0] cnt_inc,
    output logic [W-1:0] cmp_q,
    output logic         hit
);
    typedef struct packed {
        logic [W-1:0] cmp;
    } cmp_state_t;

    cmp_state_t st_d, st_q;

    assign cmp_q = st_q.cmp;
    assign hit   = step && (cnt_inc == st_q.cmp);

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.cmp = wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assert_cmp_store_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cmp_q == $past(wr_val)));

    assert_no_idle_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !step |-> !hit);
endmodule

// File: rtl/ostimer_events.sv
module ostimer_events #(
    parameter int NCH = 4,
    parameter int W   = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] hit,
    input  logic [NCH-1:0] irq_en,
    input  logic           clr_en,
    input  logic [NCH-1:0] clr_mask,
    input  logic           arm_wr,
    input  logic [W-1:0]   arm_val,
    output logic [NCH-1:0] evt_q,
    output logic [W-1:0]   arm_q,
    output logic           rst_req_q
);
    localparam int WD_CH = NCH - 1;

    typedef struct packed {
        logic [NCH-1:0] evt;
        logic [W-1:0]   arm;
        logic           rreq;
    } evt_state_t;

    evt_state_t st_d, st_q;
    logic [NCH-1:0] new_evt;
    logic           wd_fire;

    assign new_evt   = hit & irq_en;
    assign wd_fire   = hit[WD_CH] && st_q.arm[0];
    assign evt_q     = st_q.evt;
    assign arm_q     = st_q.arm;
    assign rst_req_q = st_q.rreq;

    always_comb begin
        st_d = st_q;
        if (clr_en) begin
            st_d.evt = st_q.evt & ~clr_mask;
        end
        st_d.evt = st_d.evt | new_evt;
        if (arm_wr) begin
            st_d.arm = arm_val;
        end
        if (wd_fire) begin
            st_d.arm = '0;
        end
        st_d.rreq = wd_fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_evt_chk
        assert_evt_needs_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(evt_q[g]) |-> $past(hit[g] && irq_en[g]));

        assert_evt_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (hit[g] && irq_en[g]) |=> evt_q[g]);
    end

    assert_wd_disarm_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req_q |-> (arm_q == '0));

    assert_wd_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_q) |-> $past(hit[WD_CH]));
endmodule

// File: rtl/ostimer_core.sv
module ostimer_core
    import ostimer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              bus_err,
    output logic [NUM_CH-1:0] irq,
    output logic              reset_req
);
    typedef struct packed {
        logic [CNT_W-1:0] rdata;
        logic             err;
        logic [IE_W-1:0]  ie;
    } bus_state_t;

    bus_state_t st_d, st_q;

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_inc;
    logic              step;
    logic              cnt_wr;
    logic [NUM_CH-1:0] cmp_wr;
    logic [NUM_CH-1:0] hit;
    logic [CNT_W-1:0]  cmp_val [NUM_CH];
    logic [NUM_CH-1:0] evt_q;
    logic [CNT_W-1:0]  arm_q;
    logic              evt_clr;
    logic              arm_wr;

    assign cnt_wr  = bus_wr && (bus_addr == OFS_COUNT);
    assign evt_clr = bus_wr && (bus_addr == OFS_EVENT);
    assign arm_wr  = bus_wr && (bus_addr == OFS_WDARM);

    ostimer_counter #(.W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load_en  (cnt_wr),
        .load_val (bus_wdata),
        .cnt_q    (cnt_q),
        .cnt_inc  (cnt_inc),
        .step     (step)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        assign cmp_wr[g] = bus_wr && (bus_addr == cmp_ofs(g));

        ostimer_cmp_ch #(.W(CNT_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (cmp_wr[g]),
            .wr_val  (bus_wdata),
            .step    (step),
            .cnt_inc (cnt_inc),
            .cmp_q   (cmp_val[g]),
            .hit     (hit[g])
        );
    end

    ostimer_events #(.NCH(NUM_CH), .W(CNT_W)) u_evt (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit       (hit),
        .irq_en    (st_q.ie[NUM_CH-1:0]),
        .clr_en    (evt_clr),
        .clr_mask  (bus_wdata[NUM_CH-1:0]),
        .arm_wr    (arm_wr),
        .arm_val   (bus_wdata),
        .evt_q     (evt_q),
        .arm_q     (arm_q),
        .rst_req_q (reset_req)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        if (bus_wr && (bus_addr == OFS_IRQEN)) begin
            st_d.ie = bus_wdata[IE_W-1:0];
        end
        if (bus_rd) begin
            st_d.rdata = '0;
            st_d.err   = 1'b1;
            for (int i = 0; i < NUM_CH; i++) begin
                if (bus_addr == cmp_ofs(i)) begin
                    st_d.rdata = cmp_val[i];
                    st_d.err   = 1'b0;
                end
            end
            case (bus_addr)
                OFS_COUNT: begin
                    st_d.rdata = cnt_q;
                    st_d.err   = 1'b0;
                end
                OFS_EVENT: begin
                    st_d.rdata = CNT_W'(evt_q);
                    st_d.err   = 1'b0;
                end
                OFS_WDARM: begin
                    st_d.rdata = arm_q;
                    st_d.err   = 1'b0;
                end
                OFS_IRQEN: begin
                    st_d.rdata = CNT_W'(st_q.ie);
                    st_d.err   = 1'b0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
    assign bus_err   = st_q.err;
    assign irq       = evt_q;

    assert_err_zero_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_rdata == '0));

    assert_err_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_err);

    assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    assert_wd_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> !reset_req);
endmodule

// File: tb/sim_ostimer_core.sv
module sim_ostimer_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [3:0]  irq;
    logic        reset_req;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    ostimer_core u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_err   (bus_err),
        .irq       (irq),
        .reset_req (reset_req)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic e);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata; e = bus_err;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
        end
    endtask

    task automatic t_reset;
        logic [31:0] d; logic e;
        check("R1 irq", 32'(irq), 0);
        check("R1 reset_req", 32'(reset_req), 0);
        check("R1 rdata", bus_rdata, 0);
        check("R1 err", 32'(bus_err), 0);
        for (int a = 0; a < 32; a += 4) begin
            rd(8'(a), d, e);
            check("R1 register", d, 0);
        end
    endtask

    task automatic t_count;
        logic [31:0] d; logic e;
        wr(8'h10, 32'd100);
        ticks(5);
        rd(8'h10, d, e);
        check("R2 count", d, 32'd105);
        wr(8'h10, 32'hFFFF_FFFE);
        ticks(3);
        rd(8'h10, d, e);
        check("R2 wrap", d, 32'd1);
    endtask

    task automatic t_load;
        logic [31:0] d; logic e;
        @(negedge clk);
        bus_addr = 8'h10; bus_wdata = 32'h55; bus_wr = 1'b1; tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
        rd(8'h10, d, e);
        check("R3 load over tick", d, 32'h55);
    endtask

    task automatic t_cmp_regs;
        logic [31:0] d; logic e;
        for (int c = 0; c < 4; c++) begin
            wr(8'(c * 4), 32'hA000_0000 + 32'(c));
        end
        for (int c = 0; c < 4; c++) begin
            rd(8'(c * 4), d, e);
            check("R4 compare readback", d, 32'hA000_0000 + 32'(c));
            check("R10 mapped no err", 32'(e), 0);
        end
    endtask

    task automatic t_irq_on;
        logic [31:0] d; logic e;
        wr(8'h1C, 32'h1);
        wr(8'h00, 32'd50);
        wr(8'h10, 32'd48);
        ticks(1);
        check("R5 before match", 32'(irq), 0);
        ticks(1);
        check("R5 irq at match", 32'(irq), 32'h1);
        ticks(3);
        check("R5 sticky", 32'(irq), 32'h1);
        rd(8'h14, d, e);
        check("R5 event reg", d, 32'h1);
    endtask

    task automatic t_clear;
        logic [31:0] d; logic e;
        wr(8'h14, 32'h0);
        check("R7 zero write keeps", 32'(irq), 32'h1);
        wr(8'h14, 32'h1);
        check("R7 irq cleared", 32'(irq), 0);
        rd(8'h14, d, e);
        check("R7 event cleared", d, 0);
    endtask

    task automatic t_irq_off;
        logic [31:0] d; logic e;
        wr(8'h1C, 32'h0);
        wr(8'h04, 32'd200);
        wr(8'h10, 32'd199);
        ticks(1);
        check("R6 no irq", 32'(irq), 0);
        wr(8'h1C, 32'h2);
        rd(8'h14, d, e);
        check("R6 no event after enable", d, 0);
    endtask

    task automatic t_ie_mask;
        logic [31:0] d; logic e;
        wr(8'h1C, 32'hFFFF_FFFF);
        rd(8'h1C, d, e);
        check("R8 enable mask", d, 32'h0000_0FFF);
        wr(8'h1C, 32'h0);
    endtask

    task automatic t_watchdog;
        logic [31:0] d; logic e;
        wr(8'h0C, 32'd300);
        wr(8'h18, 32'h1);
        wr(8'h10, 32'd298);
        ticks(1);
        check("R9 no early reset", 32'(reset_req), 0);
        @(negedge clk);
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        check("R9 reset pulse", 32'(reset_req), 1);
        @(negedge clk);
        check("R9 single cycle", 32'(reset_req), 0);
        rd(8'h18, d, e);
        check("R9 disarmed", d, 0);
        check("R9 no irq without enable", 32'(irq), 0);
    endtask

    task automatic t_unmapped;
        logic [31:0] d; logic e;
        rd(8'h24, d, e);
        check("R10 data zero", d, 0);
        check("R10 err set", 32'(e), 1);
        @(negedge clk);
        check("R10 err one cycle", 32'(bus_err), 0);
        rd(8'h02, d, e);
        check("R10 misaligned err", 32'(e), 1);
    endtask

    task automatic t_hold;
        logic [31:0] d; logic e;
        rd(8'h00, d, e);
        repeat (3) @(negedge clk);
        check("R12 rdata holds", bus_rdata, 32'd50);
    endtask

    task automatic t_no_retro;
        wr(8'h1C, 32'h4);
        wr(8'h10, 32'd400);
        wr(8'h08, 32'd400);
        repeat (2) @(negedge clk);
        check("R11 equal write no event", 32'(irq), 0);
        wr(8'h10, 32'd400);
        check("R11 equal load no event", 32'(irq), 0);
        ticks(1);
        check("R11 passed value", 32'(irq), 0);
    endtask

    task automatic t_set_over_clear;
        wr(8'h1C, 32'h1);
        wr(8'h00, 32'd500);
        wr(8'h10, 32'd499);
        @(negedge clk);
        bus_addr = 8'h14; bus_wdata = 32'h1; bus_wr = 1'b1; tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; tick = 1'b0;
        check("R13 set beats clear", 32'(irq), 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_count();
        t_load();
        t_cmp_regs();
        t_irq_on();
        t_clear();
        t_irq_off();
        t_ie_mask();
        t_watchdog();
        t_unmapped();
        t_hold();
        t_no_retro();
        t_set_over_clear();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++;
                n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule